// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block sets how many bus clock cycles each bus access lasts. An accepted request is classified by its address into one of three kinds of target: the on-chip register area, internal memory, or one of four external chip-select windows. The block then holds `busy` high for the length that the configuration gives that target, and pulses `done` in the final cycle. External windows run either with separate address and data phases or with multiplexed address and data. Each window has its own no-wait bit, mode bit and two-bit wait code. A global wait bit and a register-area clock-speed bit complete the configuration. Writes to a no-wait external window take one cycle longer than reads.

On external windows that run with waits, the ready input can stretch a cycle past its programmed length, one cycle at a time. Configuration arrives on plain parallel inputs. It is captured when a request is accepted and stays in force until that access completes. A wait code the block does not define, and a multiplexed window marked no-wait, each run with waits and raise `cfg_err` for the whole access.

Top module: `bus_wait_ctrl`

## Requirements
- R1: The address decodes as follows. Below 0x00400 is the register area and `area` reads 0. From 0x00400 up to 0x07FFF is internal memory and `area` reads 1. Every higher address is external, `area` reads 2, and the window index is address bits [19:18]. During an external access `cs_sel` is the one-hot of that index (bit i for window i). At all other times `cs_sel` is zero.
- R2: A register-area access lasts 2 cycles when `pll_fast_sel` is 1 and 3 cycles when it is 0.
- R3: An internal-memory access lasts 1 cycle when `glob_wait` is 0 and 2 cycles when it is 1.
- R4: This requirement covers a separate-mode external window whose no-wait bit (`cs_nowait[i]`) is 1, with `glob_wait` at 0. A read lasts 1 cycle and a write lasts 2 cycles.
- R5: This requirement covers a separate-mode external window whose no-wait bit is 0, with `glob_wait` at 0. Its wait code `cs_wcode[2i+1:2i]` sets the length: 00 gives 2 cycles, 01 gives 3 and 10 gives 4.
- R6: With `glob_wait` at 1, every separate-mode external access lasts 2 cycles, whatever the window's wait code or no-wait bit.
- R7: A window whose `cs_mux[i]` bit is 1 runs in multiplexed mode. With `glob_wait` at 1 it lasts 3 cycles. Otherwise codes 00 and 01 give 3 cycles, and 10 and 11 give 4. In this mode the no-wait bit has no effect on length. A no-wait bit of 1 raises `cfg_err`.
- R8: Wait code 11 is used whenever `glob_wait` is 0 and the window is either multiplexed or has no-wait 0. In that case the code gives 4 cycles and raises `cfg_err`. `cfg_err` is valid throughout `busy` and reads 0 when idle.
- R9: On an external window whose no-wait bit is 0, `rdy` low in the last programmed cycle delays `done`. One cycle is added for each consecutive low cycle, and `done` comes in the first cycle with `rdy` high.
- R10: `rdy` has no effect on register-area accesses, internal-memory accesses, or accesses to a window whose no-wait bit is 1.
- R11: A request seen while idle starts an access, and `busy` is high from the next cycle. `done` is high only in the last busy cycle. `busy` falls after `done`. Requests made while busy are dropped. The earliest next acceptance is the cycle after `done`.
- R12: Address, direction and all configuration inputs are captured at acceptance. Changing them during an access alters neither its length nor its outputs.
- R13: After reset, `busy`, `done`, `cfg_err` and `cs_sel` are 0. With all configuration inputs zero, internal memory takes 1 cycle and every external window takes 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, honoured while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Access address |
| glob_wait | input | 1 | Global one-wait bit |
| pll_fast_sel | input | 1 | Register-area length select (1 = 2 cycles, 0 = 3 cycles) |
| cs_nowait | input | 4 | Per-window no-wait bits |
| cs_wcode | input | 8 | Per-window two-bit wait codes |
| cs_mux | input | 4 | Per-window multiplexed-mode bits |
| rdy | input | 1 | External ready, active high |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of the access |
| area | output | 2 | Captured target kind (0 register, 1 internal, 2 external) |
| cs_sel | output | 4 | One-hot active external window |
| cfg_err | output | 1 | Captured configuration is reserved or inconsistent |

## Verification
The bench aims at several combinations where a wrong design produces the wrong length:
- The asymmetric read/write length of no-wait windows. A design that ignores direction gives writes 1 cycle.
- The precedence of the global wait bit over the code and the no-wait bit. Getting it wrong yields 1, 3 or 4 cycles instead of 2.
- The multiplexed table, where code 01 must still give 3 cycles.

The bench stalls `rdy` on every target kind. A design that listens to ready on internal or no-wait targets completes late. One that samples ready too early completes before the programmed length. The bench also scrambles every input and raises extra requests during each access. A design that fails to capture configuration, or that accepts a second request, shows the wrong length, a wrong window or a busy cycle in the idle gap.

// File: rtl/bwc_pkg.sv
// Package: shared target-kind encoding for the wait-state controller.
// Assumes the encoding values are visible on the area output port.
package bwc_pkg;
    typedef enum logic [1:0] {
        TGT_REG = 2'd0,
        TGT_MEM = 2'd1,
        TGT_EXT = 2'd2
    } tgt_t;
endpackage

// File: rtl/bwc_decode.sv
// Module: bwc_decode
// Classifies an address as register area, internal memory or external
// window, and extracts the external window index from the top bits.
// Assumes REG_LIMIT < MEM_LIMIT and that external windows tile the
// address space by their top CS_W bits.
module bwc_decode
    import bwc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int NCS       = 4,
    parameter int REG_LIMIT = 'h00400,
    parameter int MEM_LIMIT = 'h08000,
    localparam int CS_W     = $clog2(NCS)
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_t              tgt,
    output logic [CS_W-1:0]   cs_idx
);
    localparam logic [ADDR_W-1:0] REG_TOP = ADDR_W'(REG_LIMIT);
    localparam logic [ADDR_W-1:0] MEM_TOP = ADDR_W'(MEM_LIMIT);

    // Pick the target kind by comparing against the two limits.
    always_comb begin
        if (addr < REG_TOP)
            tgt = TGT_REG;
        else if (addr < MEM_TOP)
            tgt = TGT_MEM;
        else
            tgt = TGT_EXT;
    end

    // The window index is the top address bits.
    assign cs_idx = addr[ADDR_W-1 -: CS_W];
endmodule

// File: rtl/bwc_len.sv
// Module: bwc_len
// Computes the bus cycle length, whether ready is honoured, and
// whether the configuration is reserved or inconsistent, for a decoded
// target. Purely combinational; the caller captures the results.
// Assumes LEN_W can hold the value 4.
module bwc_len
    import bwc_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int LEN_W = 3,
    localparam int CS_W = $clog2(NCS)
) (
    input  tgt_t               tgt,
    input  logic [CS_W-1:0]    cs_idx,
    input  logic               wr,
    input  logic               glob_wait,
    input  logic               pll_fast_sel,
    input  logic [NCS-1:0]     cs_nowait,
    input  logic [2*NCS-1:0]   cs_wcode,
    input  logic [NCS-1:0]     cs_mux,
    output logic [LEN_W-1:0]   len,
    output logic               honour_rdy,
    output logic               cfg_bad
);
    logic       nw;
    logic       mx;
    logic [1:0] code;

    // Select the per-window configuration for the addressed window.
    always_comb begin
        nw   = cs_nowait[cs_idx];
        mx   = cs_mux[cs_idx];
        code = cs_wcode[{cs_idx, 1'b0} +: 2];
    end

    // Separate-mode code table: 00->2, 01->3, 10 and 11 ->4.
    function automatic logic [LEN_W-1:0] sep_len(input logic [1:0] c);
        case (c)
            2'b00:   sep_len = LEN_W'(2);
            2'b01:   sep_len = LEN_W'(3);
            default: sep_len = LEN_W'(4);
        endcase
    endfunction

    // Multiplexed-mode code table: 00,01->3, 10,11->4.
    function automatic logic [LEN_W-1:0] mux_len(input logic [1:0] c);
        mux_len = c[1] ? LEN_W'(4) : LEN_W'(3);
    endfunction

    // Combine target kind, global bit, mode, no-wait bit and code.
    always_comb begin
        len        = LEN_W'(1);
        honour_rdy = 1'b0;
        cfg_bad    = 1'b0;
        case (tgt)
            TGT_REG: len = pll_fast_sel ? LEN_W'(2) : LEN_W'(3);
            TGT_MEM: len = glob_wait ? LEN_W'(2) : LEN_W'(1);
            default: begin
                honour_rdy = !nw;
                if (mx) begin
                    cfg_bad = nw;
                    if (glob_wait) begin
                        len = LEN_W'(3);
                    end else begin
                        len = mux_len(code);
                        if (code == 2'b11)
                            cfg_bad = 1'b1;
                    end
                end else if (glob_wait) begin
                    len = LEN_W'(2);
                end else if (nw) begin
                    len = wr ? LEN_W'(2) : LEN_W'(1);
                end else begin
                    len     = sep_len(code);
                    cfg_bad = (code == 2'b11);
                end
            end
        endcase
    end
endmodule

// File: rtl/bwc_seq.sv
// Module: bwc_seq
// Runs one bus cycle: captures the computed length and flags at
// acceptance, counts down, then waits for ready if it is honoured.
// Assumes len is at least 1 whenever start is high.
module bwc_seq
    import bwc_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int LEN_W = 3,
    localparam int CS_W = $clog2(NCS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             honour_rdy,
    input  logic             cfg_bad,
    input  tgt_t             tgt,
    input  logic [CS_W-1:0]  cs_idx,
    input  logic             rdy,
    output logic             busy,
    output logic             done,
    output tgt_t             tgt_q,
    output logic [NCS-1:0]   cs_sel,
    output logic             cfg_err
);
    logic [LEN_W-1:0] cnt;
    logic             hon_q;
    logic [CS_W-1:0]  cs_q;

    // Access state: capture at acceptance, count, release after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            hon_q   <= 1'b0;
            cs_q    <= '0;
            tgt_q   <= TGT_REG;
            cfg_err <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                cnt     <= len - LEN_W'(1);
                hon_q   <= honour_rdy;
                cs_q    <= cs_idx;
                tgt_q   <= tgt;
                cfg_err <= cfg_bad;
            end
        end else if (done) begin
            busy    <= 1'b0;
            cfg_err <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
        end
    end

    // Completion: programmed cycles used up and ready seen if honoured.
    assign done = busy && (cnt == '0) && (!hon_q || rdy);

    // One-hot window select, driven only during external accesses.
    generate
        for (genvar i = 0; i < NCS; i++) begin : g_sel
            assign cs_sel[i] = busy && (tgt_q == TGT_EXT) && (cs_q == CS_W'(i));
        end
    endgenerate
endmodule

// File: rtl/bus_wait_ctrl.sv
// Module: bus_wait_ctrl
// Top of the bus wait-state controller: decode, length computation and
// the cycle sequencer. Configuration is plain parallel inputs and is
// captured when a request is accepted.
// Assumes the requester holds req until it sees busy or drops it.
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int NCS       = 4,
    parameter int REG_LIMIT = 'h00400,
    parameter int MEM_LIMIT = 'h08000,
    parameter int LEN_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              glob_wait,
    input  logic              pll_fast_sel,
    input  logic [NCS-1:0]    cs_nowait,
    input  logic [2*NCS-1:0]  cs_wcode,
    input  logic [NCS-1:0]    cs_mux,
    input  logic              rdy,
    output logic              busy,
    output logic              done,
    output logic [1:0]        area,
    output logic [NCS-1:0]    cs_sel,
    output logic              cfg_err
);
    localparam int CS_W = $clog2(NCS);

    tgt_t             tgt;
    tgt_t             tgt_q;
    logic [CS_W-1:0]  cs_idx;
    logic [LEN_W-1:0] len;
    logic             honour_rdy;
    logic             cfg_bad;

    bwc_decode #(
        .ADDR_W(ADDR_W), .NCS(NCS),
        .REG_LIMIT(REG_LIMIT), .MEM_LIMIT(MEM_LIMIT)
    ) u_decode (
        .addr(addr), .tgt(tgt), .cs_idx(cs_idx)
    );

    bwc_len #(.NCS(NCS), .LEN_W(LEN_W)) u_len (
        .tgt(tgt), .cs_idx(cs_idx), .wr(wr),
        .glob_wait(glob_wait), .pll_fast_sel(pll_fast_sel),
        .cs_nowait(cs_nowait), .cs_wcode(cs_wcode), .cs_mux(cs_mux),
        .len(len), .honour_rdy(honour_rdy), .cfg_bad(cfg_bad)
    );

    bwc_seq #(.NCS(NCS), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(req), .len(len),
        .honour_rdy(honour_rdy), .cfg_bad(cfg_bad),
        .tgt(tgt), .cs_idx(cs_idx), .rdy(rdy),
        .busy(busy), .done(done), .tgt_q(tgt_q),
        .cs_sel(cs_sel), .cfg_err(cfg_err)
    );

    // Present the captured target kind on the port.
    assign area = tgt_q;
endmodule

// File: rtl/bwc_checks.sv
// Module: bwc_checks
// Protocol checks on the controller's ports, bound to every instance.
module bwc_checks #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req,
    input logic           busy,
    input logic           done,
    input logic [1:0]     area,
    input logic [NCS-1:0] cs_sel,
    input logic           cfg_err
);
    logic [2:0] bcnt;

    // Count busy cycles of the current access, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            bcnt <= '0;
        else if (bcnt != 3'd7)
            bcnt <= bcnt + 3'd1;
    end

    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);
    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_sel));
    a_r1_cs_external_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_sel != '0) |-> (busy && area == 2'd2));
    a_r12_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(area) && $stable(cs_sel) && $stable(cfg_err)));
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && cs_sel == '0 && !cfg_err));
    a_r10_onchip_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && area != 2'd2) |-> (bcnt < 3'd3));
endmodule

bind bus_wait_ctrl bwc_checks #(.NCS(NCS)) u_checks (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
    .area(area), .cs_sel(cs_sel), .cfg_err(cfg_err)
);

// File: tb/bus_wait_ctrl_test.sv
module bus_wait_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [19:0] addr = '0;
    logic        glob_wait = 1'b0;
    logic        pll_fast_sel = 1'b0;
    logic [3:0]  cs_nowait = '0;
    logic [7:0]  cs_wcode = '0;
    logic [3:0]  cs_mux = '0;
    logic        rdy = 1'b1;
    logic        busy, done, cfg_err;
    logic [1:0]  area;
    logic [3:0]  cs_sel;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bus_wait_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .glob_wait(glob_wait), .pll_fast_sel(pll_fast_sel),
        .cs_nowait(cs_nowait), .cs_wcode(cs_wcode), .cs_mux(cs_mux),
        .rdy(rdy), .busy(busy), .done(done), .area(area),
        .cs_sel(cs_sel), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [19:0] a);
        if (a < 20'h00400) return 0;
        if (a < 20'h08000) return 1;
        return 2;
    endfunction

    // Length per R2..R8.
    function automatic int exp_len(input logic [19:0] a, input logic w, input logic g,
                                   input logic p, input logic [3:0] nw,
                                   input logic [7:0] wc, input logic [3:0] mx);
        int k = kind_of(a);
        int i = int'(a[19:18]);
        logic [1:0] c = wc[2*i +: 2];
        if (k == 0) return p ? 2 : 3;
        if (k == 1) return g ? 2 : 1;
        if (mx[i]) return g ? 3 : (c[1] ? 4 : 3);
        if (g) return 2;
        if (nw[i]) return w ? 2 : 1;
        return (c == 2'b00) ? 2 : (c == 2'b01) ? 3 : 4;
    endfunction

    function automatic bit exp_err(input logic [19:0] a, input logic g,
                                   input logic [3:0] nw, input logic [7:0] wc,
                                   input logic [3:0] mx);
        int i = int'(a[19:18]);
        bit code_used;
        if (kind_of(a) != 2) return 0;
        code_used = !g && (mx[i] || !nw[i]);
        return (code_used && wc[2*i +: 2] == 2'b11) || (mx[i] && nw[i]);
    endfunction

    function automatic string len_tag(input logic [19:0] a, input logic g,
                                      input logic [3:0] nw, input logic [3:0] mx);
        int i = int'(a[19:18]);
        if (kind_of(a) == 0) return "R2";
        if (kind_of(a) == 1) return "R3";
        if (mx[i]) return "R7";
        if (g) return "R6";
        if (nw[i]) return "R4";
        return "R5";
    endfunction

    // One access; stall = cycles of rdy low from the last programmed cycle.
    task automatic run(input logic [19:0] a, input logic w, input logic g, input logic p,
                       input logic [3:0] nw, input logic [7:0] wc, input logic [3:0] mx,
                       input int stall, input bit scramble);
        int  el   = exp_len(a, w, g, p, nw, wc, mx);
        bit  hon  = (kind_of(a) == 2) && !nw[a[19:18]];
        bit  ee   = exp_err(a, g, nw, wc, mx);
        int  etot = el + (hon ? stall : 0);
        int  ecs  = (kind_of(a) == 2) ? (1 << a[19:18]) : 0;
        int  got  = 0;
        string tg = len_tag(a, g, nw, mx);
        @(negedge clk);
        addr = a; wr = w; glob_wait = g; pll_fast_sel = p;
        cs_nowait = nw; cs_wcode = wc; cs_mux = mx; req = 1'b1; rdy = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (scramble) begin   // R12: inputs change during the access
            addr = 20'($urandom); wr = 1'($urandom); glob_wait = 1'($urandom);
            pll_fast_sel = 1'($urandom); cs_nowait = 4'($urandom);
            cs_wcode = 8'($urandom); cs_mux = 4'($urandom);
        end
        for (int k = 0; k < 40; k++) begin
            rdy = (k >= el - 1 + stall);
            if (scramble) req = 1'($urandom);
            #1;
            if (k == 0) begin
                check(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
                check(int'(area) == kind_of(a), "R1 area", int'(area), kind_of(a));
                check(int'(cs_sel) == ecs, "R1 cs_sel", int'(cs_sel), ecs);
                check(cfg_err == ee, "R8 cfg_err", int'(cfg_err), int'(ee));
            end
            if (!busy) begin
                check(1'b0, "R11 busy dropped before done", k, etot);
                break;
            end
            if (done) begin
                got = k + 1;
                req = 1'b0;
                break;
            end
            @(negedge clk);
        end
        if (hon && stall > 0)
            check(got == etot, "R9 stretched length", got, etot);
        else if (stall > 0)
            check(got == etot, "R10 ready ignored", got, etot);
        else
            check(got == etot, tg, got, etot);
        rdy = 1'b1;
        @(negedge clk);
        #1;
        check(!busy && !done, "R11 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !cfg_err && cs_sel == 4'd0, "R13 reset outputs", int'(busy), 0);
        rst_n = 1'b1;

        // R13: all-zero configuration.
        run(20'h01000, 0, 0, 0, 4'h0, 8'h00, 4'h0, 0, 0);
        run(20'h48000, 0, 0, 0, 4'h0, 8'h00, 4'h0, 0, 0);
        // R2
        run(20'h00010, 0, 0, 1, 4'h0, 8'h00, 4'h0, 0, 0);
        run(20'h003FF, 1, 0, 0, 4'h0, 8'h00, 4'h0, 0, 0);
        // R3
        run(20'h07FFF, 0, 1, 0, 4'h0, 8'h00, 4'h0, 0, 0);
        // R4: read 1, write 2 on window 2
        run(20'h80000, 0, 0, 0, 4'h4, 8'h00, 4'h0, 0, 0);
        run(20'h80000, 1, 0, 0, 4'h4, 8'h00, 4'h0, 0, 0);
        // R5: codes 01, 10 on window 3
        run(20'hC0000, 0, 0, 0, 4'h0, 8'h40, 4'h0, 0, 0);
        run(20'hC0000, 1, 0, 0, 4'h0, 8'h80, 4'h0, 0, 0);
        // R8: code 11 on window 0 (lowest external address)
        run(20'h08000, 0, 0, 0, 4'h0, 8'h03, 4'h0, 0, 0);
        // R6: global wait overrides code 10 and no-wait
        run(20'h40000, 0, 1, 0, 4'h0, 8'h08, 4'h0, 0, 0);
        run(20'h40000, 1, 1, 0, 4'h2, 8'h00, 4'h0, 0, 0);
        // R7: multiplexed
        run(20'h40000, 0, 0, 0, 4'h0, 8'h04, 4'h2, 0, 0);
        run(20'h40000, 0, 0, 0, 4'h0, 8'h08, 4'h2, 0, 0);
        run(20'h40000, 0, 1, 0, 4'h0, 8'h0C, 4'h2, 0, 0);
        run(20'h40000, 0, 0, 0, 4'h2, 8'h00, 4'h2, 0, 0);
        // R9: ready stretch
        run(20'hC0000, 0, 0, 0, 4'h0, 8'h00, 4'h0, 3, 0);
        run(20'h40000, 0, 0, 0, 4'h0, 8'h04, 4'h2, 1, 0);
        // R10: ready ignored
        run(20'h00100, 0, 0, 0, 4'h0, 8'h00, 4'h0, 4, 0);
        run(20'h02000, 0, 0, 0, 4'h0, 8'h00, 4'h0, 4, 0);
        run(20'h80000, 0, 0, 0, 4'h4, 8'h00, 4'h0, 4, 0);
        // R12 and R11: scrambled inputs and extra requests
        run(20'hC0000, 1, 0, 0, 4'h0, 8'h80, 4'h0, 2, 1);

        for (int n = 0; n < 400; n++) begin
            int kind = int'($urandom % 4);
            logic [19:0] a;
            if (kind == 0)      a = 20'($urandom % 32'h400);
            else if (kind == 1) a = 20'(32'h400 + $urandom % 32'h7C00);
            else                a = {2'($urandom), 18'(32'h8000 + $urandom % 32'h38000)};
            run(a, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                8'($urandom), 4'($urandom), int'($urandom % 4), 1'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule